// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Status Queue

This block turns a serial line into characters. It watches the receive line through a two-flop synchroniser and hunts for a falling edge. It confirms a start bit at mid-bit, then takes each data bit, the optional parity bit and the stop bit or bits at their centres. The timing comes from a tick input that pulses sixteen times per bit period.

Each finished character goes into a queue together with three status flags: parity error, framing error and break. Host logic pops the queue and sees an empty or full indication at all times. A character that arrives while the queue is full is discarded. That loss raises a sticky overrun indication, which only an explicit clear command removes.

The receiver handles every character on its own. After the last stop sample it goes straight back to hunting for the next start bit. After a low stop sample it first waits for the line to go high again.

Top module: `srx_top`

## Requirements
- R1: After reset the queue reports empty, not full, and no overrun.
- R2: Each queue entry is 11 bits. Bits [7:0] hold the character, first-received bit at bit 0. Bit 8 is parity error, bit 9 is framing error and bit 10 is break. `cfg_len_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits above the selected length read as zero.
- R3: A low level on the line that has gone high again by mid-bit (8 ticks after the falling edge) starts no character and writes nothing to the queue.
- R4: With `cfg_par_en_i` high, one parity bit follows the data. `cfg_par_odd_i`=1 asks for an odd count of ones over data plus parity, and 0 asks for an even count. A mismatch sets bit 8. With parity disabled, bit 8 is always 0.
- R5: A stop bit sampled low sets bit 9. With `cfg_two_stop_i` high, the second stop bit is sampled as well, and a low there also sets bit 9. After a low stop sample, the receiver waits for the line to go high before it hunts again.
- R6: When all data bits, the parity bit (if enabled) and the first stop bit are zero, the entry has bits 10 and 9 set and data 0. A line held low for longer than one character yields exactly one entry.
- R7: Entries leave the queue in arrival order. `rd_en_i` pops the head only when the queue is not empty, and a pop on an empty queue has no effect. `full_o` is high when the queue holds FIFO_DEPTH entries.
- R8: A character that completes while the queue is full is dropped, and `overrun_o` is set. `overrun_o` stays set until `clr_ovr_i` is pulsed. Entries already queued are not disturbed.
- R9: With one stop bit, a start bit that begins right at the end of the previous stop bit is received, so back-to-back characters are all captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling strobe, 16 pulses per bit |
| cfg_len_i | input | 2 | Character length: 0..3 selects 5..8 bits |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop_i | input | 1 | Sample two stop bits |
| clr_ovr_i | input | 1 | Clears the sticky overrun flag |
| rd_en_i | input | 1 | Pop the queue head |
| rd_data_o | output | 11 | Queue head: {break, framing, parity, data[7:0]} |
| empty_o | output | 1 | Queue holds no entries |
| full_o | output | 1 | Queue holds FIFO_DEPTH entries |
| overrun_o | output | 1 | Sticky: a character was lost to a full queue |

## Verification
An off-centre sample counter shows up within one character. The result is shifted data bits, or a spurious parity or framing flag, in the very next popped entry. A hunt state that fails to wait after a low stop bit shows up as a second, phantom entry a bit time later. A queue pointer or count that slips appears within a depth's worth of pops: as a repeated entry, a wrong order, or an empty or full flag that disagrees with the number of characters sent minus those read. A misbehaving overrun latch is seen on the flag right after the first character past capacity, or as a stale flag after the clear.

// File: rtl/srx_pkg.sv
package srx_pkg;

   // receiver sequencing states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2,
      ST_HOLD
   } rx_state_t;

   // status flag offsets above the data field of a queue entry
   localparam int PERR_OFS = 0;
   localparam int FERR_OFS = 1;
   localparam int BRK_OFS  = 2;
   localparam int STAT_W   = 3;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("srx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rx_i,
   input  logic                     tick_i,
   input  logic [1:0]               cfg_len_i,
   input  logic                     par_en_i,
   input  logic                     par_odd_i,
   input  logic                     two_stop_i,
   output logic                     push_o,
   output logic [DATA_W+STAT_W-1:0] entry_o
);

   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

   if (DATA_W < 8) begin : g_bad_width
      $error("srx_framer: DATA_W must hold an 8-bit character");
   end
   if ((OVS < 4) || ((OVS & (OVS - 1)) != 0)) begin : g_bad_ovs
      $error("srx_framer: OVS must be a power of two, at least 4");
   end

   rx_state_t         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BIT_W-1:0]  bit_idx_q;
   logic [DATA_W-1:0] shreg_q;
   logic              par_bit_q;

   logic [BIT_W-1:0]  len_bits;
   logic [BIT_W-1:0]  align_sh;
   logic [DATA_W-1:0] aligned;
   logic              par_err;
   logic              all_zero;
   logic              centre;

   assign len_bits = BIT_W'(cfg_len_i) + BIT_W'(5);
   assign align_sh = BIT_W'(DATA_W) - len_bits;
   assign aligned  = shreg_q >> align_sh;
   assign par_err  = par_en_i && ((^aligned ^ par_bit_q) != par_odd_i);
   assign all_zero = (aligned == '0) && (!par_en_i || !par_bit_q);
   assign centre   = tick_i && (cnt_q == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         bit_idx_q <= '0;
         shreg_q   <= '0;
         par_bit_q <= 1'b0;
         push_o    <= 1'b0;
         entry_o   <= '0;
      end else begin
         push_o <= 1'b0;
         if (tick_i && (state_q != ST_IDLE) && (state_q != ST_HOLD))
            cnt_q <= cnt_q + CNT_W'(1);
         unique case (state_q)
            ST_IDLE: begin
               if (tick_i && !rx_i) begin
                  state_q <= ST_START;
                  cnt_q   <= '0;
               end
            end
            ST_START: begin
               if (tick_i && (cnt_q == MID_CNT)) begin
                  cnt_q     <= '0;
                  bit_idx_q <= '0;
                  shreg_q   <= '0;
                  par_bit_q <= 1'b0;
                  state_q   <= rx_i ? ST_IDLE : ST_DATA;
               end
            end
            ST_DATA: begin
               if (centre) begin
                  shreg_q   <= {rx_i, shreg_q[DATA_W-1:1]};
                  bit_idx_q <= bit_idx_q + BIT_W'(1);
                  if (bit_idx_q == len_bits - BIT_W'(1))
                     state_q <= par_en_i ? ST_PAR : ST_STOP1;
               end
            end
            ST_PAR: begin
               if (centre) begin
                  par_bit_q <= rx_i;
                  state_q   <= ST_STOP1;
               end
            end
            ST_STOP1: begin
               if (centre) begin
                  if (rx_i && two_stop_i) begin
                     state_q <= ST_STOP2;
                  end else begin
                     push_o  <= 1'b1;
                     entry_o <= {!rx_i && all_zero, !rx_i, par_err, aligned};
                     state_q <= rx_i ? ST_IDLE : ST_HOLD;
                  end
               end
            end
            ST_STOP2: begin
               if (centre) begin
                  push_o  <= 1'b1;
                  entry_o <= {1'b0, !rx_i, par_err, aligned};
                  state_q <= rx_i ? ST_IDLE : ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (rx_i) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R6
   brk_implies_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_o && entry_o[DATA_W+BRK_OFS] |->
         entry_o[DATA_W+FERR_OFS] && (entry_o[DATA_W-1:0] == '0));

   // R2
   unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> ((entry_o[DATA_W-1:0] >> len_bits) == {DATA_W{1'b0}}));

   // R4
   no_perr_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_o && !par_en_i |-> !entry_o[DATA_W+PERR_OFS]);

   // R3
   start_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA) && $past(state_q == ST_START) |-> $past(!rx_i && tick_i));

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int WIDTH = 11,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             pop_i,
   input  logic             clr_ovr_i,
   output logic [WIDTH-1:0] data_o,
   output logic             empty_o,
   output logic             full_o,
   output logic             overrun_o
);

   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("srx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
   logic [AW:0]      count_q;
   logic             push_ok, pop_ok;

   assign empty_o = (count_q == '0);
   assign full_o  = (count_q == FULL_CNT);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;
   assign data_o  = mem[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr_q] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q  <= '0;
         rd_ptr_q  <= '0;
         count_q   <= '0;
         overrun_o <= 1'b0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + AW'(1);
         if (push_ok && !pop_ok)      count_q <= count_q + (AW+1)'(1);
         else if (pop_ok && !push_ok) count_q <= count_q - (AW+1)'(1);
         overrun_o <= (push_i && full_o) || (overrun_o && !clr_ovr_i);
      end
   end

   // R7
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !empty_o && !push_i |=> count_q == $past(count_q) - (AW+1)'(1));

   // R8
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> $past(push_i && full_o));

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o && !clr_ovr_i |=> overrun_o);

   // R7
   no_dual_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty_o && full_o));

endmodule

// File: rtl/srx_top.sv
module srx_top
   import srx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int FIFO_DEPTH  = 16,
   parameter int SYNC_STAGES = 2,
   localparam int ENTRY_W    = DATA_W + STAT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rxd_i,
   input  logic               tick_i,
   input  logic [1:0]         cfg_len_i,
   input  logic               cfg_par_en_i,
   input  logic               cfg_par_odd_i,
   input  logic               cfg_two_stop_i,
   input  logic               clr_ovr_i,
   input  logic               rd_en_i,
   output logic [ENTRY_W-1:0] rd_data_o,
   output logic               empty_o,
   output logic               full_o,
   output logic               overrun_o
);

   logic               rx_sync;
   logic               fr_push;
   logic [ENTRY_W-1:0] fr_entry;

   srx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd_i),
      .q_o   (rx_sync)
   );

   srx_framer #(
      .DATA_W (DATA_W),
      .OVS    (OVS)
   ) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_i       (rx_sync),
      .tick_i     (tick_i),
      .cfg_len_i  (cfg_len_i),
      .par_en_i   (cfg_par_en_i),
      .par_odd_i  (cfg_par_odd_i),
      .two_stop_i (cfg_two_stop_i),
      .push_o     (fr_push),
      .entry_o    (fr_entry)
   );

   srx_fifo #(
      .WIDTH (ENTRY_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (fr_push),
      .data_i    (fr_entry),
      .pop_i     (rd_en_i),
      .clr_ovr_i (clr_ovr_i),
      .data_o    (rd_data_o),
      .empty_o   (empty_o),
      .full_o    (full_o),
      .overrun_o (overrun_o)
   );

endmodule

// File: tb/sim_srx_top.sv
module sim_srx_top;

   localparam int DEPTH = 16;
   localparam int BIT_CLKS = 32; // 16 ticks, one tick every 2 clocks

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rxd = 1'b1;
   logic        tick = 1'b0;
   logic [1:0]  cfg_len = 2'd3;
   logic        cfg_pe = 1'b0, cfg_odd = 1'b0, cfg_two = 1'b0;
   logic        clr_ovr = 1'b0, rd_en = 1'b0;
   logic [10:0] rd_data;
   logic        empty, full, overrun;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [10:0] exp_q [0:63];
   int q_head = 0, q_tail = 0;

   always #5 clk = ~clk;

   srx_top #(.FIFO_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick_i(tick),
      .cfg_len_i(cfg_len), .cfg_par_en_i(cfg_pe), .cfg_par_odd_i(cfg_odd),
      .cfg_two_stop_i(cfg_two), .clr_ovr_i(clr_ovr), .rd_en_i(rd_en),
      .rd_data_o(rd_data), .empty_o(empty), .full_o(full), .overrun_o(overrun)
   );

   initial begin
      forever begin
         @(negedge clk);
         tick = ~tick;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [10:0] expect_entry(input logic [7:0] d, input int len,
         input bit pe, input bit odd, input bit bad_par, input bit stop_low, input bit stop2_low);
      logic [7:0] m;
      logic pbit;
      m = d & 8'((1 << len) - 1);
      pbit = (^m) ^ odd ^ bad_par;
      return {stop_low && (m == 8'h00) && (!pe || !pbit),
              stop_low || stop2_low, pe && bad_par, m};
   endfunction

   task automatic line_bit(input logic v);
      rxd = v;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int len, input bit pe, input bit odd,
         input bit two, input bit bad_par, input bit stop_low, input bit stop2_low, input int gap);
      logic [7:0] m;
      m = d & 8'((1 << len) - 1);
      cfg_len = 2'(len - 5);
      cfg_pe = pe; cfg_odd = odd; cfg_two = two;
      line_bit(1'b0);
      for (int i = 0; i < len; i++) line_bit(m[i]);
      if (pe) line_bit((^m) ^ odd ^ bad_par);
      line_bit(!stop_low);
      if (two && !stop_low) line_bit(!stop2_low);
      rxd = 1'b1;
      exp_q[q_tail % 64] = expect_entry(d, len, pe, odd, bad_par, stop_low, two && !stop_low && stop2_low);
      q_tail++;
      repeat (gap) line_bit(1'b1);
   endtask

   task automatic pop_check(input string tag);
      check({tag, " not empty"}, {31'd0, empty}, 32'd0);
      check({tag, " entry"}, {21'd0, rd_data}, {21'd0, exp_q[q_head % 64]});
      q_head++;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 empty", {31'd0, empty}, 32'd1);
      check("R1 full", {31'd0, full}, 32'd0);
      check("R1 overrun", {31'd0, overrun}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R7 pop while empty has no effect
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
      check("R7 empty after idle pop", {31'd0, empty}, 32'd1);
      send(8'hA5, 8, 0, 0, 0, 0, 0, 0, 1);
      pop_check("R7 first entry after idle pop");
      check("R7 empty after one pop", {31'd0, empty}, 32'd1);

      // R3 false start
      rxd = 1'b0; repeat (8) @(negedge clk);
      rxd = 1'b1; repeat (2 * BIT_CLKS) @(negedge clk);
      check("R3 false start ignored", {31'd0, empty}, 32'd1);
      send(8'h3C, 8, 0, 0, 0, 0, 0, 0, 1);
      pop_check("R3 recovery");

      // R2 R4 R5 random frames
      for (int n = 0; n < 36; n++) begin
         logic [7:0] d;
         int len;
         bit pe, odd, two, bp, sl, s2;
         d = 8'($urandom);
         len = 5 + int'($urandom % 4);
         pe = 1'($urandom); odd = 1'($urandom); two = 1'($urandom);
         bp = pe && (($urandom % 4) == 0);
         sl = (($urandom % 8) == 0);
         s2 = two && (($urandom % 6) == 0);
         send(d, len, pe, odd, two, bp, sl, s2, 1);
         pop_check("R2 R4 R5 random frame");
      end

      // R4 directed parity cases
      send(8'h07, 8, 1, 0, 0, 1, 0, 0, 1); pop_check("R4 even mismatch");
      send(8'h07, 8, 1, 1, 0, 0, 0, 0, 1); pop_check("R4 odd ok");
      // R5 directed stop errors
      send(8'h55, 7, 0, 0, 0, 0, 1, 0, 1); pop_check("R5 stop low");
      send(8'h55, 7, 0, 0, 1, 0, 0, 1, 1); pop_check("R5 second stop low");
      // R2 short length zero fill
      send(8'hFF, 5, 0, 0, 0, 0, 0, 0, 1); pop_check("R2 five bit zero fill");

      // R6 break: line low for 12 bit times
      cfg_len = 2'd3; cfg_pe = 1'b0; cfg_two = 1'b0;
      rxd = 1'b0; repeat (12 * BIT_CLKS) @(negedge clk);
      rxd = 1'b1; repeat (2 * BIT_CLKS) @(negedge clk);
      exp_q[q_tail % 64] = 11'h600; q_tail++;
      pop_check("R6 break entry");
      check("R6 single break entry", {31'd0, empty}, 32'd1);

      // R9 back-to-back characters
      send(8'h11, 8, 0, 0, 0, 0, 0, 0, 0);
      send(8'h22, 8, 0, 0, 0, 0, 0, 0, 0);
      send(8'h83, 8, 0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 3; i++) pop_check("R9 back-to-back");

      // R8 overrun: DEPTH+1 characters without reading
      for (int i = 0; i < DEPTH + 1; i++) begin
         send(8'(i * 7 + 1), 8, 0, 0, 0, 0, 0, 0, 1);
         if (i < DEPTH) check("R7 full flag while filling", {31'd0, full}, {31'd0, i == DEPTH - 1});
      end
      q_tail--; // last character is dropped
      check("R8 overrun set", {31'd0, overrun}, 32'd1);
      check("R7 full", {31'd0, full}, 32'd1);
      for (int i = 0; i < DEPTH; i++) pop_check("R8 R7 drain order");
      check("R8 empty after drain", {31'd0, empty}, 32'd1);
      check("R8 overrun sticky", {31'd0, overrun}, 32'd1);
      clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0; @(negedge clk);
      check("R8 overrun cleared", {31'd0, overrun}, 32'd0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule